// File: doc/BRIEF.md
# Memory Bit Invert Read-Modify-Write Unit

This unit carries out a single-bit toggle on a byte held in memory. An issue stage hands it both halfwords of the instruction, together with the values of the two general registers that the instruction names. The unit decodes which of its two encodings is present. It forms the byte address and fetches the byte over a byte-wide memory port. It then flips the chosen bit, stores the byte back, and publishes the new value of that bit as the zero flag.

There are two encodings. In the immediate encoding, the bit number is a 3-bit field inside the first halfword. The address is the base register plus the second halfword, sign-extended. In the register encoding, the second halfword is a fixed sub-opcode. The address is the base register itself, and the bit number comes from the low three bits of a second register. While a toggle is in progress the unit takes no new work, so the read and the write form one uninterrupted pair on the memory port. The memory answers each access with an acknowledge, and it may stretch any access by wait cycles.

Top module: `bitinv_rmw_unit`

## Requirements
- R1: The immediate encoding is recognised when the first halfword has bits [15:14] = 01 and bits [10:5] = 111110. Its bit number is bits [13:11]. Its address is req_base plus the second halfword sign-extended to the address width, wrapping modulo 2^AW.
- R2: The register encoding is recognised when the first halfword has bits [10:5] = 111111 and the second halfword equals 16'h00E2. Its address is req_base unchanged, and its bit number is req_bitsrc[2:0]; the higher bits of req_bitsrc are ignored.
- R3: A request with any other encoding is dropped. It causes no memory access, no op_done pulse and no change of zf, and the unit stays ready.
- R4: Bit 0 is the least significant bit of the byte. After a read, the unit writes the read byte back to the same address with only the selected bit inverted; every other bit keeps the value it had when read.
- R5: When the write is acknowledged, the unit pulses op_done for one cycle, and from that cycle on zf holds the inverted value of the original bit. At all other times zf keeps its value.
- R6: With no wait states, a request accepted at one clock edge gives mem_rd in the next cycle and mem_wr in the cycle after that. op_done follows one cycle later, in the same cycle in which req_ready returns high, so a toggle occupies three cycles.
- R7: A read or write that is not acknowledged stays asserted, with the same address (and, for a write, the same data), until mem_ack is high. mem_rd and mem_wr are never high together.
- R8: req_ready is low from acceptance until the write is acknowledged. A request presented during that time is neither accepted nor allowed to change the address or data in flight.
- R9: During and after reset the unit is idle: req_ready is 1, and mem_rd, mem_wr, op_done and zf are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Instruction offered for execution |
| req_ready | output | 1 | Unit idle; a legal offer is taken at this edge |
| req_hw0 | input | 16 | First instruction halfword |
| req_hw1 | input | 16 | Second instruction halfword |
| req_base | input | AW | Value of the base register |
| req_bitsrc | input | DW | Value of the register supplying the bit number (register encoding) |
| mem_rd | output | 1 | Byte read request |
| mem_wr | output | 1 | Byte write request |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 8 | Byte to store |
| mem_rdata | input | 8 | Byte returned by the read |
| mem_ack | input | 1 | Current access completes this cycle |
| op_done | output | 1 | One-cycle pulse when the toggle finishes |
| zf | output | 1 | Zero flag, equal to the new value of the toggled bit |

## Verification
The hardest situation to reach from the ports is a second instruction arriving while a toggle is stalled between its read and its write. That case needs the memory to hold back its acknowledge, and it needs a competing request with a different address present during that stall. The directed stimulus plays the memory itself, cycle by cycle. It holds mem_ack low for chosen counts on each access and keeps a legal conflicting request asserted throughout the wait. It then checks that the address, the written byte and the timing of op_done all belong to the first instruction only.

// File: rtl/bitinv_pkg.sv
package bitinv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } rmw_state_e;

    // Encoding constants of the two instruction forms
    localparam logic [1:0]  IMM_PREFIX   = 2'b01;
    localparam logic [5:0]  IMM_OPFIELD  = 6'b111110;
    localparam logic [5:0]  REG_OPFIELD  = 6'b111111;
    localparam logic [15:0] REG_SUBCODE  = 16'h00E2;

endpackage

// File: rtl/bitinv_decode.sv
module bitinv_decode
    import bitinv_pkg::*;
#(
    parameter int HW_W   = 16,
    parameter int BIDX_W = 3
) (
    input  logic [HW_W-1:0]   hw0,
    input  logic [HW_W-1:0]   hw1,
    output logic              form_imm,
    output logic              form_reg,
    output logic [BIDX_W-1:0] imm_bit
);

    logic [5:0] opfield;
    logic       unused_regfields;

    always_comb begin
        opfield  = hw0[10:5];
        form_imm = (hw0[15:14] == IMM_PREFIX) && (opfield == IMM_OPFIELD);
        form_reg = (opfield == REG_OPFIELD) && (hw1 == REG_SUBCODE);
        imm_bit  = hw0[11 +: BIDX_W];
    end

    assign unused_regfields = ^{hw0[4:0], hw0[HW_W-1:11+BIDX_W]};

endmodule

// File: rtl/bitinv_addr.sv
module bitinv_addr #(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int DISP_W = 16,
    parameter int BIDX_W = 3
) (
    input  logic              form_reg,
    input  logic [AW-1:0]     base,
    input  logic [DISP_W-1:0] disp,
    input  logic [BIDX_W-1:0] imm_bit,
    input  logic [DW-1:0]     bitsrc,
    output logic [AW-1:0]     addr,
    output logic [BIDX_W-1:0] bit_idx
);

    localparam int EXT_W = AW - DISP_W;

    logic [AW-1:0] disp_ext;
    logic          unused_bitsrc_hi;

    always_comb begin
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        if (form_reg) begin
            addr    = base;
            bit_idx = bitsrc[BIDX_W-1:0];
        end else begin
            addr    = base + disp_ext;
            bit_idx = imm_bit;
        end
    end

    assign unused_bitsrc_hi = ^bitsrc[DW-1:BIDX_W];

endmodule

// File: rtl/bitinv_modify.sv
module bitinv_modify #(
    parameter int BYTE_W = 8,
    parameter int BIDX_W = $clog2(BYTE_W)
) (
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [BIDX_W-1:0] idx,
    output logic [BYTE_W-1:0] byte_out
);

    for (genvar i = 0; i < BYTE_W; i++) begin : g_lane
        assign byte_out[i] = byte_in[i] ^ (idx == BIDX_W'(i));
    end

endmodule

// File: rtl/bitinv_rmw_unit.sv
module bitinv_rmw_unit
    import bitinv_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int DISP_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [15:0]       req_hw0,
    input  logic [15:0]       req_hw1,
    input  logic [AW-1:0]     req_base,
    input  logic [DW-1:0]     req_bitsrc,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [AW-1:0]     mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              op_done,
    output logic              zf
);

    localparam int BIDX_W = $clog2(BYTE_W);

    typedef struct packed {
        rmw_state_e        st;
        logic [AW-1:0]     addr;
        logic [BIDX_W-1:0] idx;
        logic [BYTE_W-1:0] data;
        logic              z;
        logic              done;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic              form_imm, form_reg, legal;
    logic [BIDX_W-1:0] imm_bit, calc_idx;
    logic [AW-1:0]     calc_addr;
    logic [BYTE_W-1:0] flipped;

    bitinv_decode #(.HW_W(16), .BIDX_W(BIDX_W)) u_decode (
        .hw0      (req_hw0),
        .hw1      (req_hw1),
        .form_imm (form_imm),
        .form_reg (form_reg),
        .imm_bit  (imm_bit)
    );

    bitinv_addr #(.AW(AW), .DW(DW), .DISP_W(DISP_W), .BIDX_W(BIDX_W)) u_addr (
        .form_reg (form_reg),
        .base     (req_base),
        .disp     (req_hw1[DISP_W-1:0]),
        .imm_bit  (imm_bit),
        .bitsrc   (req_bitsrc),
        .addr     (calc_addr),
        .bit_idx  (calc_idx)
    );

    bitinv_modify #(.BYTE_W(BYTE_W), .BIDX_W(BIDX_W)) u_modify (
        .byte_in  (mem_rdata),
        .idx      (ctx_q.idx),
        .byte_out (flipped)
    );

    assign legal = form_imm | form_reg;

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.done = 1'b0;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid && legal) begin
                    ctx_d.st   = ST_READ;
                    ctx_d.addr = calc_addr;
                    ctx_d.idx  = calc_idx;
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    ctx_d.data = flipped;
                    ctx_d.st   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    ctx_d.z    = ctx_q.data[ctx_q.idx];
                    ctx_d.done = 1'b1;
                    ctx_d.st   = ST_IDLE;
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign req_ready = (ctx_q.st == ST_IDLE);
    assign mem_rd    = (ctx_q.st == ST_READ);
    assign mem_wr    = (ctx_q.st == ST_WRITE);
    assign mem_addr  = ctx_q.addr;
    assign mem_wdata = mem_wr ? ctx_q.data : '0;
    assign op_done   = ctx_q.done;
    assign zf        = ctx_q.z;

    // Checker-side copy of the byte seen on the read
    logic [BYTE_W-1:0] rd_byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                rd_byte_q <= '0;
        else if (mem_rd && mem_ack) rd_byte_q <= mem_rdata;
    end

    a_r7_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r7_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr)));

    a_r7_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ack) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    a_r4_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr) |-> ($past(mem_rd && mem_ack) && $stable(mem_addr)));

    a_r4_single_bit_changed: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($countones(mem_wdata ^ rd_byte_q) == 1));

    a_r5_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> $past(mem_wr && mem_ack));

    a_r5_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
        !op_done |-> $stable(zf));

    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> !req_ready);

    a_r3_illegal_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && !legal) |=> req_ready);

endmodule

// File: tb/bitinv_rmw_unit_test.sv
module bitinv_rmw_unit_test;

    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [15:0]   req_hw0 = '0;
    logic [15:0]   req_hw1 = '0;
    logic [AW-1:0] req_base = '0;
    logic [DW-1:0] req_bitsrc = '0;
    logic          mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = '0;
    logic          mem_ack = 1'b0;
    logic          op_done, zf;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    bitinv_rmw_unit uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_hw0(req_hw0), .req_hw1(req_hw1),
        .req_base(req_base), .req_bitsrc(req_bitsrc),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .op_done(op_done), .zf(zf)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] imm_hw0(input logic [2:0] b);
        return {2'b01, b, 6'b111110, 5'd3};
    endfunction

    function automatic logic [15:0] reg_hw0();
        return {5'd7, 6'b111111, 5'd3};
    endfunction

    // Issue one toggle and play the memory; noise keeps a rival request up while busy
    task automatic run_toggle(input logic [15:0] hw0, input logic [15:0] hw1,
                              input logic [31:0] base, input logic [31:0] bitsrc,
                              input logic [31:0] exp_addr, input int bitn,
                              input logic [7:0] mem_byte, input int rd_wait,
                              input int wr_wait, input bit noise, input string req);
        logic [7:0] exp_wr;
        logic       exp_z;
        exp_wr = mem_byte ^ (8'h01 << bitn);
        exp_z  = exp_wr[bitn];
        @(negedge clk);
        check(req_ready, req, "ready before issue", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_hw0 = hw0; req_hw1 = hw1;
        req_base = base; req_bitsrc = bitsrc;
        @(negedge clk);
        if (noise) begin
            req_hw0 = imm_hw0(3'd6); req_hw1 = 16'h0100; req_base = 32'h0000_9000;
        end else begin
            req_valid = 1'b0;
        end
        for (int i = 0; i < rd_wait; i++) begin
            check(mem_rd && !mem_wr, req, "read held", {31'd0, mem_rd}, 32'd1);
            check(mem_addr == exp_addr, req, "read addr in wait", mem_addr, exp_addr);
            check(!req_ready, "R8", "busy during read", {31'd0, req_ready}, 32'd0);
            @(negedge clk);
        end
        check(mem_rd && !mem_wr, "R6", "read cycle", {30'd0, mem_rd, mem_wr}, 32'd2);
        check(mem_addr == exp_addr, req, "read address", mem_addr, exp_addr);
        mem_rdata = mem_byte; mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0; mem_rdata = 8'h00;
        for (int i = 0; i < wr_wait; i++) begin
            check(mem_wr && !mem_rd, "R7", "write held", {31'd0, mem_wr}, 32'd1);
            check(mem_wdata == exp_wr, "R7", "write data in wait", {24'd0, mem_wdata}, {24'd0, exp_wr});
            check(!req_ready, "R8", "busy during write", {31'd0, req_ready}, 32'd0);
            @(negedge clk);
        end
        check(mem_wr && !mem_rd, "R6", "write cycle", {30'd0, mem_rd, mem_wr}, 32'd1);
        check(mem_addr == exp_addr, "R4", "write address", mem_addr, exp_addr);
        check(mem_wdata == exp_wr, "R4", "written byte", {24'd0, mem_wdata}, {24'd0, exp_wr});
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        req_valid = 1'b0;
        check(op_done, "R5", "done pulse", {31'd0, op_done}, 32'd1);
        check(zf == exp_z, "R5", "zero flag", {31'd0, zf}, {31'd0, exp_z});
        check(req_ready && !mem_rd && !mem_wr, "R6", "idle after done", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        check(!op_done, "R5", "done is one cycle", {31'd0, op_done}, 32'd0);
        check(zf == exp_z, "R5", "flag holds", {31'd0, zf}, {31'd0, exp_z});
        check(!mem_rd, "R8", "rival not started", {31'd0, mem_rd}, 32'd0);
    endtask

    task automatic run_illegal(input logic [15:0] hw0, input logic [15:0] hw1,
                               input logic exp_z);
        @(negedge clk);
        req_valid = 1'b1; req_hw0 = hw0; req_hw1 = hw1; req_base = 32'h0000_4000;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check(!mem_rd && !mem_wr, "R3", "no access", {30'd0, mem_rd, mem_wr}, 32'd0);
            check(req_ready && !op_done, "R3", "still idle", {30'd0, req_ready, op_done}, 32'd2);
            check(zf == exp_z, "R3", "flag unchanged", {31'd0, zf}, {31'd0, exp_z});
            @(negedge clk);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(req_ready, "R9", "ready in reset", {31'd0, req_ready}, 32'd1);
        check(!mem_rd && !mem_wr, "R9", "no access in reset", {30'd0, mem_rd, mem_wr}, 32'd0);
        check(!op_done && !zf, "R9", "done/flag in reset", {30'd0, op_done, zf}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !mem_rd && !mem_wr && !zf, "R9", "idle after reset", {31'd0, req_ready}, 32'd1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        test_reset();
        // R1: immediate form, positive displacement, bit 0 from clear byte
        run_toggle(imm_hw0(3'd0), 16'h0010, 32'h0000_1000, 32'h0, 32'h0000_1010, 0, 8'h00, 0, 0, 0, "R1");
        // R1: negative displacement, bit 7 of a full byte
        run_toggle(imm_hw0(3'd7), 16'hFFF0, 32'h0000_2000, 32'h0, 32'h0000_1FF0, 7, 8'hFF, 0, 0, 0, "R1");
        // R1: address wraps past the top
        run_toggle(imm_hw0(3'd3), 16'h0020, 32'hFFFF_FFF0, 32'h0, 32'h0000_0010, 3, 8'h3C, 0, 0, 0, "R1");
        // R2: register form, upper bitsrc bits set, low three = 5
        run_toggle(reg_hw0(), 16'h00E2, 32'h0000_3456, 32'hFFFF_FFFD, 32'h0000_3456, 5, 8'hA5, 0, 0, 0, "R2");
        // R7: register form with wait states on both accesses
        run_toggle(reg_hw0(), 16'h00E2, 32'h0001_0000, 32'h0000_0012, 32'h0001_0000, 2, 8'h5A, 2, 3, 0, "R7");
        // R8: rival request held up across a stalled toggle
        run_toggle(imm_hw0(3'd4), 16'h0004, 32'h0000_5000, 32'h0, 32'h0000_5004, 4, 8'hEF, 3, 2, 1, "R8");
        // R3: wrong sub-opcode, wrong prefix, unrelated opcode field
        run_illegal(reg_hw0(), 16'h00E0, zf);
        run_illegal({2'b11, 3'd2, 6'b111110, 5'd1}, 16'h0000, zf);
        run_illegal(16'h0000, 16'h00E2, zf);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule